// File: doc/BRIEF.md
# Three-Source Minterm Word Blitter

This block is a streaming logic engine. For each step it fetches three 16-bit source words (A, B and C) from one word address. It combines them bit by bit through an 8-bit truth table and hands the result word to a destination port, tagged with the address it came from. The same table is applied to every bit position of a word at once, and again to each word of a run of a programmed length. The run walks memory upward or downward from a programmed base address.

In fill mode the result of the table is passed through a running toggle. The toggle moves from the least significant bit toward the most significant bit and keeps its last state from one word to the next, much like a carry. For that reason fill is accepted only when the run walks downward. Software sets the block up through four write-only registers and then launches the run. It watches `busy`, `done` and `cfg_err`. Sources are fetched one word at a time with a request held until data arrives, and results leave through a valid/ready handshake that may stall for any length of time.

Top module: `tri_src_blitter`

## Requirements
- R1: With the table written at register index 0 (bits 7:0), result bit i equals table bit number {A[i],B[i],C[i]}, where A is the most significant bit of the 3-bit index, for every i in 0..15.
- R2: A table value of 0xF0 outputs source A unchanged, and a table value of 0x00 outputs all zeros.
- R3: Writing register index 3 with bit 2 (go) set starts a run from the base address held at register index 2. Bit 0 of that write selects the direction: 0 counts addresses up by one per word, 1 counts them down by one per word.
- R4: A run produces exactly as many destination words as the count held at register index 1, and each destination word carries the address its sources were read from.
- R5: With bit 1 (fill) of the control write set, output bit i is a toggle state: it starts at 0 when the run launches, flips at every bit where the table result is 1 (scanned from bit 0 upward), and carries its value from bit 15 of one word into bit 0 of the next word.
- R6: A go write that asks for fill together with the upward direction, or that finds a count of zero, sets `cfg_err` and starts nothing. A later accepted go write clears `cfg_err`.
- R7: `busy` rises on the clock edge that takes an accepted go write and falls on the edge that accepts the last destination word. On that same edge `done` rises, and it stays high for exactly one cycle.
- R8: While `dst_valid` is high and `dst_ready` is low, `dst_valid`, `dst_data` and `dst_addr` hold their values, and no result word is lost or repeated.
- R9: Once raised, `src_req` and `src_addr` hold until `src_valid` is seen.
- R10: Register writes made while `busy` is high are ignored, both by the run in progress and by later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 table, 1 count, 2 base, 3 control |
| cfg_wdata | input | 16 | Register write data |
| src_req | output | 1 | Source fetch request |
| src_addr | output | 16 | Word address for the three sources |
| src_valid | input | 1 | Source words present on src_a/b/c |
| src_a | input | 16 | Source A word |
| src_b | input | 16 | Source B word |
| src_c | input | 16 | Source C word |
| dst_valid | output | 1 | Result word offered |
| dst_ready | input | 1 | Destination accepts the result |
| dst_addr | output | 16 | Address of the result word |
| dst_data | output | 16 | Result word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last go write was rejected |

## Verification
The bench goes after the fill toggle crossing word boundaries in a downward run. A design that reset the toggle per word, or scanned from the wrong end, would give wrong words from the second word on. Single-word runs and runs that wrap the address past zero test the count and the address step, where an off-by-one design would emit one word too many or repeat an address. A long-stalling random sink exposes a design that changes or drops the offered word while `dst_ready` is low. Writes poked in the middle of a run, together with rejected go writes, catch a design that lets a reconfiguration take effect, or that starts on a forbidden fill setup.

// File: rtl/blit_pkg.sv
// Shared definitions for the three-source blitter.
// Assumes a 2-bit register index on the configuration port.
package blit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } seq_state_t;

    localparam logic [1:0] REG_TABLE = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_BASE  = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    localparam int CTRL_DOWN = 0;
    localparam int CTRL_FILL = 1;
    localparam int CTRL_GO   = 2;
endpackage

// File: rtl/blit_regs.sv
// Configuration registers and launch decode.
// Holds the table, the count, the base address and the mode bits. Writes are
// dropped while a run is active. A go write is accepted only when the mode
// and the count make sense; otherwise the error flag is set.
// Assumes CNT_W and ADDR_W are no wider than REG_W.
module blit_regs
    import blit_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              busy,
    output logic [7:0]        table_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [ADDR_W-1:0] base_q,
    output logic              down_q,
    output logic              fill_q,
    output logic              launch,
    output logic              cfg_err
);
    logic wr_ok;
    logic go_req;
    logic bad_cfg;

    // Purpose: qualify writes and decide whether a go request may start.
    assign wr_ok   = cfg_we && !busy;
    assign go_req  = wr_ok && (cfg_addr == REG_CTRL) && cfg_wdata[CTRL_GO];
    assign bad_cfg = (cfg_wdata[CTRL_FILL] && !cfg_wdata[CTRL_DOWN]) || (count_q == '0);
    assign launch  = go_req && !bad_cfg;

    // Purpose: store configuration fields on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_q <= '0;
            count_q <= '0;
            base_q  <= '0;
            down_q  <= 1'b0;
            fill_q  <= 1'b0;
        end else if (wr_ok) begin
            unique case (cfg_addr)
                REG_TABLE: table_q <= cfg_wdata[7:0];
                REG_COUNT: count_q <= cfg_wdata[CNT_W-1:0];
                REG_BASE:  base_q  <= cfg_wdata[ADDR_W-1:0];
                default: begin
                    down_q <= cfg_wdata[CTRL_DOWN];
                    fill_q <= cfg_wdata[CTRL_FILL];
                end
            endcase
        end
    end

    // Purpose: record the outcome of the most recent go request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (go_req) begin
            cfg_err <= bad_cfg;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(table_q) && $stable(count_q) && $stable(base_q)
                              && $stable(down_q) && $stable(fill_q))); // R10
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy); // R6
endmodule

// File: rtl/blit_lut.sv
// Bitwise three-input table and fill toggle chain.
// Each bit picks one table entry indexed by {A,B,C}. In fill mode a toggle
// ripples from bit 0 upward, starting from fill_in, and its final state is
// returned as fill_out. Purely combinational.
module blit_lut #(
    parameter int DATA_W = 16
) (
    input  logic [7:0]        table_q,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    input  logic              fill_en,
    input  logic              fill_in,
    output logic [DATA_W-1:0] y,
    output logic              fill_out
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W:0]   chain;

    assign chain[0] = fill_in;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // Purpose: table lookup and toggle step for one bit position.
        assign raw[i]     = table_q[{a[i], b[i], c[i]}];
        assign chain[i+1] = chain[i] ^ raw[i];
    end

    // Purpose: select plain table output or the toggle states.
    assign y        = fill_en ? chain[DATA_W:1] : raw;
    assign fill_out = chain[DATA_W];
endmodule

// File: rtl/blit_seq.sv
// Word sequencer: issues one source fetch, registers the combined result,
// offers it downstream, then steps the address and repeats for the count.
// Assumes the source side returns data with src_valid while src_req is high,
// and that the configuration inputs are stable while busy.
module blit_seq
    import blit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [CNT_W-1:0]  count_q,
    input  logic              down_q,
    input  logic              fill_q,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] lut_y,
    input  logic              lut_carry,
    input  logic              dst_ready,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    output logic              dst_valid,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [DATA_W-1:0] dst_data,
    output logic              fill_carry,
    output logic              busy,
    output logic              done
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic              last_word;

    // Purpose: detect the final word of the run.
    assign last_word = (left_q == CNT_W'(1));

    // Purpose: run state, address walk, result capture and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            left_q     <= '0;
            dst_addr   <= '0;
            dst_data   <= '0;
            fill_carry <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q    <= ST_FETCH;
                        addr_q     <= base_q;
                        left_q     <= count_q;
                        fill_carry <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (src_valid) begin
                        dst_data   <= lut_y;
                        dst_addr   <= addr_q;
                        fill_carry <= fill_q ? lut_carry : 1'b0;
                        state_q    <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (dst_ready) begin
                        if (last_word) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            left_q  <= left_q - CNT_W'(1);
                            addr_q  <= down_q ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
                            state_q <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode handshake and status outputs from the state.
    assign src_req   = (state_q == ST_FETCH);
    assign src_addr  = addr_q;
    assign dst_valid = (state_q == ST_EMIT);
    assign busy      = (state_q != ST_IDLE);

    AST_FILL_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_q) |-> down_q); // R6
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (src_req && src_addr == $past(base_q))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_ready && !last_word) |=>
        (src_addr == (down_q ? dst_addr - ADDR_W'(1) : dst_addr + ADDR_W'(1)))); // R3
    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !fill_carry); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready) |=>
        (dst_valid && $stable(dst_data) && $stable(dst_addr))); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_valid) |=> (src_req && $stable(src_addr))); // R9
endmodule

// File: rtl/tri_src_blitter.sv
// Top of the three-source blitter: registers, sequencer and bitwise table.
// Assumes one source fetch is outstanding at a time and a 16-bit register port.
module tri_src_blitter #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [DATA_W-1:0] dst_data,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    logic [7:0]        table_q;
    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] base_q;
    logic              down_q;
    logic              fill_q;
    logic              launch;
    logic [DATA_W-1:0] lut_y;
    logic              lut_carry;
    logic              fill_carry;

    blit_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .busy(busy), .table_q(table_q), .count_q(count_q),
        .base_q(base_q), .down_q(down_q), .fill_q(fill_q), .launch(launch),
        .cfg_err(cfg_err)
    );

    blit_lut #(.DATA_W(DATA_W)) u_lut (
        .table_q(table_q), .a(src_a), .b(src_b), .c(src_c), .fill_en(fill_q),
        .fill_in(fill_carry), .y(lut_y), .fill_out(lut_carry)
    );

    blit_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .base_q(base_q),
        .count_q(count_q), .down_q(down_q), .fill_q(fill_q),
        .src_valid(src_valid), .lut_y(lut_y), .lut_carry(lut_carry),
        .dst_ready(dst_ready), .src_req(src_req), .src_addr(src_addr),
        .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_data(dst_data),
        .fill_carry(fill_carry), .busy(busy), .done(done)
    );
endmodule

// File: tb/tri_src_blitter_test.sv
`timescale 1ns/1ps
module tri_src_blitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        src_req;
    logic [15:0] src_addr;
    logic        src_valid = 1'b0;
    logic [15:0] src_a = '0, src_b = '0, src_c = '0;
    logic        dst_valid;
    logic        dst_ready = 1'b0;
    logic [15:0] dst_addr, dst_data;
    logic        busy, done, cfg_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit sink_on = 1'b0;
    logic [15:0] salt_a = 16'h3C5A, salt_b = 16'hA1B2, salt_c = 16'h0F0F;
    logic [15:0] rec_addr [0:63];
    logic [15:0] rec_data [0:63];
    int rec_cnt = 0;

    always #2.5 clk = ~clk;

    tri_src_blitter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .src_req(src_req), .src_addr(src_addr),
        .src_valid(src_valid), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr),
        .dst_data(dst_data), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    function automatic logic [15:0] mem_a(input logic [15:0] ad);
        return 16'(ad * 16'h9E37) ^ salt_a;
    endfunction
    function automatic logic [15:0] mem_b(input logic [15:0] ad);
        return 16'(ad * 16'h6A09) ^ salt_b;
    endfunction
    function automatic logic [15:0] mem_c(input logic [15:0] ad);
        return {ad[7:0], ad[15:8]} ^ salt_c;
    endfunction

    function automatic logic [15:0] ref_lut(input logic [7:0] m,
                                            input logic [15:0] a, b, c);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = m[{a[i], b[i], c[i]}];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] ad, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Source responder: answers a held request after a short random delay (R9).
    initial begin
        int dly = 0;
        bit prev_req = 1'b0;
        logic [15:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            if (prev_req && !src_valid)
                chk(src_req && src_addr == prev_addr, "R9 request held",
                    {15'd0, src_req, src_addr}, {16'd1, prev_addr});
            src_valid = 1'b0;
            prev_req = src_req;
            prev_addr = src_addr;
            if (src_req) begin
                if (dly == 0) begin
                    src_valid = 1'b1;
                    src_a = mem_a(src_addr);
                    src_b = mem_b(src_addr);
                    src_c = mem_c(src_addr);
                    dly = int'($urandom % 3);
                end else dly--;
            end
        end
    end

    // Destination sink: random ready, logs transfers, checks stall hold (R8).
    initial begin
        bit held = 1'b0;
        logic [15:0] h_addr = '0, h_data = '0;
        forever begin
            @(negedge clk);
            if (held)
                chk(dst_valid && dst_addr == h_addr && dst_data == h_data,
                    "R8 stalled word held", {dst_addr, dst_data}, {h_addr, h_data});
            dst_ready = sink_on && (($urandom % 4) != 0);
            held = dst_valid && !dst_ready;
            h_addr = dst_addr;
            h_data = dst_data;
            if (dst_valid && dst_ready && rec_cnt < 64) begin
                rec_addr[rec_cnt] = dst_addr;
                rec_data[rec_cnt] = dst_data;
                rec_cnt++;
            end
        end
    end

    // Runs one job and compares every result word against the model.
    task automatic run_job(input logic [7:0] m, input int n, input logic [15:0] base,
                           input bit dn, input bit fl, input bit wr_cfg,
                           input bit poke, input string tag);
        int guard = 0;
        bit tog = 1'b0;
        if (wr_cfg) begin
            cfg_write(2'd0, {8'd0, m});
            cfg_write(2'd1, 16'(n));
            cfg_write(2'd2, base);
        end
        rec_cnt = 0;
        cfg_write(2'd3, {13'd0, 1'b1, fl, dn});
        chk(busy === 1'b1, "R7 busy after go", {31'd0, busy}, 32'd1);
        if (poke) begin
            cfg_write(2'd0, 16'h0000);
            cfg_write(2'd1, 16'd1);
            cfg_write(2'd2, 16'h7777);
            cfg_write(2'd3, 16'h0004);
        end
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1, "R7 done seen", {31'd0, done}, 32'd1);
        chk(busy === 1'b0, "R7 idle at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R7 done one cycle", {31'd0, done}, 32'd0);
        chk(rec_cnt == n, "R4 word count", 32'(rec_cnt), 32'(n));
        for (int k = 0; k < n && k < rec_cnt; k++) begin
            logic [15:0] ad, r, e;
            ad = dn ? base - 16'(k) : base + 16'(k);
            r = ref_lut(m, mem_a(ad), mem_b(ad), mem_c(ad));
            if (fl) begin
                for (int i = 0; i < 16; i++) begin
                    tog = tog ^ r[i];
                    e[i] = tog;
                end
            end else e = r;
            chk(rec_addr[k] == ad, "R3 address order", {16'd0, rec_addr[k]}, {16'd0, ad});
            chk(rec_data[k] == e, tag, {16'd0, rec_data[k]}, {16'd0, e});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2E3F40));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !src_req && !dst_valid && !cfg_err, "R7 reset state",
            {27'd0, busy, done, src_req, dst_valid, cfg_err}, 32'd0);
        sink_on = 1'b1;

        // Directed corner cases.
        run_job(8'hF0, 5, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b0, "R2 copy A");
        run_job(8'h00, 4, 16'h0200, 1'b1, 1'b0, 1'b1, 1'b0, "R2 clear");
        run_job(8'hE8, 1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R1 majority single word");
        run_job(8'h96, 3, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0, "R1 parity wraps below zero");
        run_job(8'hF0, 6, 16'h0040, 1'b1, 1'b1, 1'b1, 1'b0, "R5 fill copy A");
        run_job(8'h3C, 7, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, "R5 fill xor");

        // Writes during a run are ignored, now and for the next run (R10).
        run_job(8'h5A, 6, 16'h0300, 1'b0, 1'b0, 1'b1, 1'b1, "R10 running job unaffected");
        run_job(8'h5A, 6, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0, "R10 later job unaffected");

        // Rejected go writes (R6).
        cfg_write(2'd1, 16'd4);
        cfg_write(2'd3, 16'h0006);
        chk(cfg_err === 1'b1, "R6 fill upward rejected", {31'd0, cfg_err}, 32'd1);
        chk(busy === 1'b0, "R6 no start on fill upward", {31'd0, busy}, 32'd0);
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            chk(!src_req && !dst_valid, "R6 no activity after reject",
                {30'd0, src_req, dst_valid}, 32'd0);
        end
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd3, 16'h0005);
        chk(cfg_err === 1'b1 && busy === 1'b0, "R6 zero count rejected",
            {30'd0, cfg_err, busy}, 32'd2);
        run_job(8'hCA, 2, 16'h0500, 1'b0, 1'b0, 1'b1, 1'b0, "R1 mux after reject");
        chk(cfg_err === 1'b0, "R6 error cleared by good go", {31'd0, cfg_err}, 32'd0);

        // Random jobs.
        for (int j = 0; j < 40; j++) begin
            logic [7:0]  m;
            logic [15:0] bs;
            bit dn, fl;
            int n;
            m  = 8'($urandom);
            bs = 16'($urandom);
            dn = 1'($urandom);
            fl = dn && 1'($urandom);
            n  = 1 + int'($urandom % 12);
            salt_a = 16'($urandom);
            run_job(m, n, bs, dn, fl, 1'b1, 1'b0, fl ? "R5 random fill" : "R1 random table");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule